// File: doc/BRIEF.md
# Inverse Haar Image Synthesis Engine

This block rebuilds a square grey-level image from a multi-level Haar decomposition that already sits in a shared word memory. The memory holds the coarsest approximation quadrant in its top-left corner and the shrunk detail quadrants around it, in the usual in-place layout. After a start pulse, the engine works from the coarsest level to the finest. At each level it first inverts the column direction and then the row direction. Each result goes back to the same memory, and a one-cycle done pulse marks the end.

The analysis stage already halved each sum and difference. Reconstruction is therefore a plain add/subtract butterfly with no shift and no multiplier. Each memory line of the active square is read into a local line buffer, one word per cycle. After a single settle cycle the reconstructed line is written back over the same locations. On the last level only, the row results are clamped to an 8-bit pixel range before they are written.

The memory side is a plain synchronous single-port interface. It is not a valid/ready stream, because the engine never waits. The memory must return read data exactly one cycle after a read strobe, and it must accept a write in the cycle it is strobed, with no back-pressure. `start` and `done` are plain control pins.

Top module: `ihaar_synth`

## Requirements
- R1: After reset, `done`, `mem_rd` and `mem_wr` are low, and they stay low until a start is accepted.
- R2: For a segment of width 2w, the value at segment position i (i < w) is the approximation `a` and the value at position w+i is the detail `d`. Position 2i receives a+d and position 2i+1 receives a-d, with no shift applied.
- R3: With L levels requested, the first level works on the top-left square of side 2·(N>>L), where N is the image side. The square side doubles after each level, and exactly L levels are performed.
- R4: Within a level, all columns of the active square are inverted before any row. Columns and rows are taken in increasing index order, and elements within a line are taken in increasing order. The word address is row·N + column.
- R5: Values written during the last level's row pass are clamped to the range 0..255. All earlier writes keep the full signed two's-complement result, truncated to the coefficient width and not clamped.
- R6: `done` is high for exactly one cycle. The number of cycles after the start-sampling edge until `done` is seen equals the sum, over the levels, of 2·(2w)·(4w+1), where w is the half-side of the square at that level.
- R7: A start asserted while a reconstruction is running has no effect on the results or on the timing.
- R8: A level count of 0 gives `done` with no memory access. A level count above log2(N) is treated as log2(N).
- R9: Read and write strobes are never high together. Every line's writes follow a cycle with no memory strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin reconstruction (sampled while idle) |
| levels | input | LVL_W | Number of decomposition levels to undo |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 2·log2(N) | Word address, row·N + column |
| mem_rd | output | 1 | Read strobe; data expected on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | COEF_W | Write data |
| mem_rdata | input | COEF_W | Read data, one cycle after `mem_rd` |

## Verification
The bench checks the full memory image after each run, so a wrong level width, a skipped pass or a mis-paired buffer index corrupts many words. Such faults show up at the end of the run that caused them. A wrong pass order or a wrong line order shows up at the first write of a level, because the traced write addresses differ. The bench compares the start-to-done cycle count against the closed-form count. This catches a counter that stops early or late, even when the results happen to match.

// File: rtl/ihaar_pkg.sv
package ihaar_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_SETTLE,
    ST_WRITE,
    ST_FIN
  } ihaar_state_t;

  typedef enum logic {
    PASS_COL,
    PASS_ROW
  } ihaar_pass_t;
endpackage

// File: rtl/ihaar_seq.sv
module ihaar_seq
  import ihaar_pkg::*;
#(
  parameter int IMG_SIZE = 8,
  parameter int LVL_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [LVL_W-1:0]          levels,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [2*$clog2(IMG_SIZE)-1:0] mem_addr,
  output logic                      cap_vld,
  output logic [$clog2(IMG_SIZE)-1:0] cap_idx,
  output logic [$clog2(IMG_SIZE)-1:0] a_idx,
  output logic [$clog2(IMG_SIZE)-1:0] d_idx,
  output logic                      odd,
  output logic                      sat_en,
  output logic                      done
);
  localparam int LOG_N = $clog2(IMG_SIZE);
  localparam int CNT_W = LOG_N + 1;
  localparam logic [CNT_W-1:0] N_CNT = CNT_W'(IMG_SIZE);
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(LOG_N);

  ihaar_state_t      state;
  ihaar_pass_t       pass;
  logic [CNT_W-1:0]  half;
  logic [LOG_N-1:0]  line;
  logic [LOG_N-1:0]  elem;

  logic [LVL_W-1:0]  eff_lvl;
  logic [CNT_W-1:0]  half_init;
  logic [CNT_W-1:0]  seg;
  logic [LOG_N-1:0]  seg_last;
  logic              last_level;

  always_comb begin
    eff_lvl    = (levels > MAX_LVL) ? MAX_LVL : levels;
    half_init  = N_CNT >> eff_lvl;
    seg        = half << 1;
    seg_last   = LOG_N'(seg - CNT_W'(1));
    last_level = (seg == N_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pass    <= PASS_COL;
      half    <= '0;
      line    <= '0;
      elem    <= '0;
      cap_vld <= 1'b0;
      cap_idx <= '0;
    end else begin
      cap_vld <= (state == ST_READ);
      cap_idx <= elem;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            pass  <= PASS_COL;
            line  <= '0;
            elem  <= '0;
            half  <= half_init;
            state <= (eff_lvl == '0) ? ST_FIN : ST_READ;
          end
        end
        ST_READ: begin
          if (elem == seg_last) begin
            elem  <= '0;
            state <= ST_SETTLE;
          end else begin
            elem <= elem + 1'b1;
          end
        end
        ST_SETTLE: state <= ST_WRITE;
        ST_WRITE: begin
          if (elem != seg_last) begin
            elem <= elem + 1'b1;
          end else begin
            elem  <= '0;
            state <= ST_READ;
            if (line != seg_last) begin
              line <= line + 1'b1;
            end else begin
              line <= '0;
              if (pass == PASS_COL) begin
                pass <= PASS_ROW;
              end else if (last_level) begin
                state <= ST_FIN;
              end else begin
                pass <= PASS_COL;
                half <= seg;
              end
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_rd   = (state == ST_READ);
    mem_wr   = (state == ST_WRITE);
    mem_addr = (pass == PASS_COL) ? {elem, line} : {line, elem};
    a_idx    = elem >> 1;
    d_idx    = (elem >> 1) + half[LOG_N-1:0];
    odd      = elem[0];
    sat_en   = (state == ST_WRITE) && (pass == PASS_ROW) && last_level;
    done     = (state == ST_FIN);
  end

  // R9: one strobe at a time
  p_no_dual_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R9: a gap cycle separates the last read from the first write
  p_settle_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> !$past(mem_rd));
  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: zero levels finishes at once
  p_zero_levels_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && start && levels == '0) |=> (done && !mem_rd && !mem_wr));
  // R1: quiet while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!mem_rd && !mem_wr && !done));
endmodule

// File: rtl/ihaar_linebuf.sv
module ihaar_linebuf #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [$clog2(DEPTH)-1:0] a_idx,
  input  logic [$clog2(DEPTH)-1:0] d_idx,
  output logic [DATA_W-1:0]        a_val,
  output logic [DATA_W-1:0]        d_val
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(e))) slot[e] <= wr_data;
    end
  end

  always_comb begin
    a_val = slot[a_idx];
    d_val = slot[d_idx];
  end
endmodule

// File: rtl/ihaar_butterfly.sv
module ihaar_butterfly #(
  parameter int COEF_W = 16,
  parameter int PIX_W  = 8
) (
  input  logic [COEF_W-1:0] a_val,
  input  logic [COEF_W-1:0] d_val,
  input  logic              odd,
  input  logic              sat_en,
  output logic [COEF_W-1:0] y
);
  localparam logic signed [COEF_W:0] PIX_HI = (COEF_W+1)'((1 << PIX_W) - 1);

  logic signed [COEF_W:0] a_x, d_x, sum;

  always_comb begin
    a_x = {a_val[COEF_W-1], a_val};
    d_x = {d_val[COEF_W-1], d_val};
    sum = odd ? (a_x - d_x) : (a_x + d_x);
    if (!sat_en)              y = sum[COEF_W-1:0];
    else if (sum < 0)         y = '0;
    else if (sum > PIX_HI)    y = PIX_HI[COEF_W-1:0];
    else                      y = sum[COEF_W-1:0];
  end
endmodule

// File: rtl/ihaar_synth.sv
module ihaar_synth #(
  parameter int IMG_SIZE = 8,
  parameter int COEF_W   = 16,
  parameter int PIX_W    = 8,
  parameter int LVL_W    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [LVL_W-1:0]              levels,
  output logic                          done,
  output logic [2*$clog2(IMG_SIZE)-1:0] mem_addr,
  output logic                          mem_rd,
  output logic                          mem_wr,
  output logic [COEF_W-1:0]             mem_wdata,
  input  logic [COEF_W-1:0]             mem_rdata
);
  localparam int LOG_N = $clog2(IMG_SIZE);
  localparam logic signed [COEF_W-1:0] PIX_TOP = COEF_W'((1 << PIX_W) - 1);

  logic             cap_vld, odd, sat_en;
  logic [LOG_N-1:0] cap_idx, a_idx, d_idx;
  logic [COEF_W-1:0] a_val, d_val;

  ihaar_seq #(.IMG_SIZE(IMG_SIZE), .LVL_W(LVL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .levels(levels),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .cap_vld(cap_vld), .cap_idx(cap_idx), .a_idx(a_idx), .d_idx(d_idx),
    .odd(odd), .sat_en(sat_en), .done(done)
  );

  ihaar_linebuf #(.DEPTH(IMG_SIZE), .DATA_W(COEF_W)) u_buf (
    .clk(clk), .wr_en(cap_vld), .wr_idx(cap_idx), .wr_data(mem_rdata),
    .a_idx(a_idx), .d_idx(d_idx), .a_val(a_val), .d_val(d_val)
  );

  ihaar_butterfly #(.COEF_W(COEF_W), .PIX_W(PIX_W)) u_bfly (
    .a_val(a_val), .d_val(d_val), .odd(odd), .sat_en(sat_en), .y(mem_wdata)
  );

  // R5: final pixels inside the 8-bit range
  p_final_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && sat_en) |-> ($signed(mem_wdata) >= 0 && $signed(mem_wdata) <= PIX_TOP));
  // R6: no memory activity right after completion
  p_quiet_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!mem_rd && !mem_wr));
endmodule

// File: tb/test_ihaar_synth.sv
module test_ihaar_synth;
  localparam int N     = 8;
  localparam int W     = 16;
  localparam int LVLW  = 4;
  localparam int WORDS = N * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LVLW-1:0] levels = '0;
  logic done, mem_rd, mem_wr;
  logic [5:0] mem_addr;
  logic [W-1:0] mem_wdata, mem_rdata;

  logic [W-1:0] tbmem [WORDS];
  logic [W-1:0] refm  [WORDS];
  int acc_cnt = 0;
  int wcount  = 0;
  int wtrace [80];
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  ihaar_synth #(.IMG_SIZE(N), .COEF_W(W), .PIX_W(8), .LVL_W(LVLW)) i_ihaar_synth (
    .clk(clk), .rst_n(rst_n), .start(start), .levels(levels), .done(done),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= tbmem[mem_addr];
    if (mem_wr) begin
      tbmem[mem_addr] <= mem_wdata;
      if (wcount < 80) wtrace[wcount] <= int'(mem_addr);
      wcount <= wcount + 1;
    end
    if (mem_rd || mem_wr) acc_cnt <= acc_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] trunc(input int v);
    return W'(v);
  endfunction

  function automatic logic [W-1:0] clamp8(input int v);
    if (v < 0) return '0;
    if (v > 255) return W'(255);
    return W'(v);
  endfunction

  function automatic int eff(input int lvl);
    return (lvl > 3) ? 3 : lvl;
  endfunction

  function automatic int exp_cycles(input int lvl);
    int n = 0;
    for (int s = eff(lvl); s >= 1; s--) begin
      int w = N >> s;
      n += 2 * (2 * w) * (4 * w + 1);
    end
    return n;
  endfunction

  task automatic ref_inverse(input int lvl);
    int L = eff(lvl);
    int tmp [N];
    for (int s = L; s >= 1; s--) begin
      int w = N >> s;
      bit fin = (s == 1);
      for (int c = 0; c < 2 * w; c++) begin
        for (int k = 0; k < 2 * w; k++) tmp[k] = int'($signed(refm[k*N+c]));
        for (int i = 0; i < w; i++) begin
          refm[(2*i)*N+c]   = trunc(tmp[i] + tmp[w+i]);
          refm[(2*i+1)*N+c] = trunc(tmp[i] - tmp[w+i]);
        end
      end
      for (int r = 0; r < 2 * w; r++) begin
        for (int k = 0; k < 2 * w; k++) tmp[k] = int'($signed(refm[r*N+k]));
        for (int i = 0; i < w; i++) begin
          refm[r*N+2*i]   = fin ? clamp8(tmp[i] + tmp[w+i]) : trunc(tmp[i] + tmp[w+i]);
          refm[r*N+2*i+1] = fin ? clamp8(tmp[i] - tmp[w+i]) : trunc(tmp[i] - tmp[w+i]);
        end
      end
    end
  endtask

  task automatic fill_random(input int lo, input int hi);
    for (int i = 0; i < WORDS; i++) tbmem[i] = trunc(int'($urandom_range(hi - lo)) + lo);
  endtask

  task automatic run(input int lvl, input bit poke, input string req);
    int cnt = 0;
    for (int i = 0; i < WORDS; i++) refm[i] = tbmem[i];
    wcount = 0;
    @(negedge clk);
    levels = LVLW'(lvl);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (!done && cnt < 20000) begin
      start = poke && (cnt == 5);
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    start = 1'b0;
    check({req, " R6 cycles"}, cnt, exp_cycles(lvl));
    @(posedge clk);
    @(negedge clk);
    check("R6 done pulse width", int'(done), 0);
    ref_inverse(lvl);
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < WORDS; i++)
      check(req, int'($signed(tbmem[i])), int'($signed(refm[i])));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int acc0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 done", int'(done), 0);
    check("R1 rd", int'(mem_rd), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle wr", int'(mem_wr), 0);
    check("R1 idle access count", acc_cnt, 0);

    // R2: hand-computed butterfly, one level
    for (int i = 0; i < WORDS; i++) tbmem[i] = '0;
    tbmem[0] = 16'd50; tbmem[4] = 16'd7; tbmem[32] = 16'd3; tbmem[36] = 16'd1;
    run(1, 1'b0, "R2");
    check("R2 pix00", int'(tbmem[0]), 61);
    check("R2 pix01", int'(tbmem[1]), 45);
    check("R2 pix10", int'(tbmem[8]), 53);
    check("R2 pix11", int'(tbmem[9]), 41);
    // R4: column pass precedes row pass, increasing order
    check("R4 first write addr", wtrace[0], 0);
    check("R4 second write addr (column)", wtrace[1], 8);
    check("R4 first row-pass write", wtrace[64], 0);
    check("R4 second row-pass write", wtrace[65], 1);

    // R3/R5: random content across level counts
    for (int t = 0; t < 3; t++) begin
      fill_random(-150, 250);
      run(3, 1'b0, "R3");
      compare("R3 R5 three levels");
    end
    fill_random(-100, 300);
    run(2, 1'b0, "R3");
    compare("R3 two levels");
    fill_random(-100, 300);
    run(1, 1'b0, "R3");
    compare("R3 one level");

    // R5: saturation high and low
    for (int i = 0; i < WORDS; i++) tbmem[i] = '0;
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) tbmem[r*N+c] = 16'd300;
    run(1, 1'b0, "R5");
    for (int i = 0; i < WORDS; i++) check("R5 clamp high", int'(tbmem[i]), 255);
    for (int i = 0; i < WORDS; i++) tbmem[i] = '0;
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) tbmem[r*N+c] = trunc(-20);
    run(1, 1'b0, "R5");
    for (int i = 0; i < WORDS; i++) check("R5 clamp low", int'(tbmem[i]), 0);

    // R7: start during a run ignored
    fill_random(-150, 250);
    run(3, 1'b1, "R7");
    compare("R7 restart ignored");

    // R8: zero levels and over-range levels
    fill_random(-150, 250);
    acc0 = acc_cnt;
    run(0, 1'b0, "R8");
    check("R8 zero levels no access", acc_cnt - acc0, 0);
    compare("R8 zero levels memory unchanged");
    fill_random(-150, 250);
    run(9, 1'b0, "R8");
    compare("R8 over-range clamps to max");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule